// File: doc/BRIEF.md
# Parallel Host Register Port

This block is the device side of an 8080-style strobe bus for a display controller. A host drives an active-low chip select, a register select, separate active-low write and read strobes and an 18-line data bus. The block turns these into accesses to an internal index register and, through a small register-file port, to the control register that the index names.

Four bus widths are available, chosen by a static 4-bit mode input: 18, 16, 9 and 8 bits. The narrow modes move a 16-bit register value in two transfers, upper byte first, and a one-bit toggle tracks which half comes next. The bus strobes are asynchronous to the internal clock and pass through a synchronizer. A write acts on the synchronized rising edge of the write strobe. Read data is driven combinationally while chip select and the read strobe are both low. The tristate buffer sits outside the block: it presents the read data and an output enable.

Top module: `hbus_port`

## Requirements
- R1: Mode 4'b0010 is the 16-bit mode. A control-register write stores the value {db_in[17:10], db_in[8:1]}, with db_in[17:10] as the upper byte. Line 9 and line 0 are ignored.
- R2: Mode 4'b1010 is the 18-bit mode. A control-register write uses the same mapping as R1, and lines 9 and 0 have no effect on the value stored.
- R3: Mode 4'b0011 is the 8-bit mode. A control-register write takes two transfers on db_in[17:10]: the upper byte comes first and the lower byte second. reg_wr pulses only after the second transfer.
- R4: Mode 4'b1011 is the 9-bit mode. It behaves like R3 on db_in[17:10], and line 9 is ignored.
- R5: Every other mode code is disabled. Under a disabled code no strobe changes the index or pulses reg_wr, and db_oe stays low.
- R6: While cs_n is high, both strobes are ignored and db_oe is low.
- R7: A write with rs low loads the index and produces no reg_wr. In the wide modes the index comes from db_in[8:1]; in the narrow modes it comes from db_in[17:10]. An index write also sends the next narrow transfer back to the upper byte.
- R8: A write with rs high and a full word assembled raises reg_wr for exactly one cycle, with reg_addr equal to the index. The pulse is visible after the third rising clock edge that follows the rising edge of wr_n.
- R9: db_oe is high exactly when cs_n and rd_n are both low and the mode is enabled. In the wide modes, a read with rs high drives the upper byte of reg_rdata on db_out[17:10] and the lower byte on db_out[8:1], and drives zero on lines 9 and 0.
- R10: In the narrow modes, a read with rs high drives the upper byte on db_out[17:10] first. After rd_n rises, the next read drives the lower byte. All other lines are zero.
- R11: A read with rs low returns the index, on db_out[8:1] in the wide modes and on db_out[17:10] in the narrow modes.
- R12: After reset the index is 0, the next narrow transfer is the upper byte, reg_wr is low, and db_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 4 | Static bus-width mode code |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 0 selects the index, 1 selects the control register |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| db_in | input | 18 | Data bus as seen at the pads |
| db_out | output | 18 | Read data for the pad drivers |
| db_oe | output | 1 | Pad output enable |
| reg_wr | output | 1 | One-cycle control-register write pulse |
| reg_addr | output | 8 | Current index, used as the register-file address |
| reg_wdata | output | 16 | Control-register write data |
| reg_rdata | input | 16 | Register-file read data at reg_addr |

## Verification
The results of a write arrive three clock edges after wr_n rises: two edges pass through the synchronizer and one registers the action. The bench therefore stamps the cycle in which it raises the strobe and compares it with the cycle in which a negative-edge monitor sees reg_wr. It samples the index and the register contents only after it has waited several more cycles. Read data and db_oe are combinational from the pins, so the bench samples them a few negative edges after it lowers rd_n. It checks the narrow-mode toggle only once the rd_n rise has had five cycles to pass through the synchronizer.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int BUS_W  = 18;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 8;

  typedef enum logic [2:0] {BW_OFF, BW_8, BW_9, BW_16, BW_18} bus_width_e;

  function automatic bus_width_e decode_mode(input logic [3:0] m);
    case (m)
      4'b0010: return BW_16;
      4'b0011: return BW_8;
      4'b1010: return BW_18;
      4'b1011: return BW_9;
      default: return BW_OFF;
    endcase
  endfunction

  function automatic logic is_narrow(input bus_width_e w);
    return (w == BW_8) || (w == BW_9);
  endfunction

  // wide modes skip lines 9 and 0
  function automatic logic [WORD_W-1:0] wide_word(input logic [BUS_W-1:0] d);
    return {d[17:10], d[8:1]};
  endfunction

  function automatic logic [7:0] narrow_byte(input logic [BUS_W-1:0] d);
    return d[17:10];
  endfunction

  function automatic logic [BUS_W-1:0] place_wide(input logic [WORD_W-1:0] v);
    return {v[15:8], 1'b0, v[7:0], 1'b0};
  endfunction

  function automatic logic [BUS_W-1:0] place_narrow(input logic [7:0] b);
    return {b, 10'b0};
  endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '1;
        else if (i == 0) stage[i] <= d;
        else stage[i] <= stage[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hbus_capture.sv
module hbus_capture
  import hbus_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  bus_width_e         width,
  input  logic               cs_s,
  input  logic               rs_s,
  input  logic               wr_s,
  input  logic               rd_s,
  input  logic [BUS_W-1:0]   data_s,
  output logic [IDX_W-1:0]   index,
  output logic               second_half,
  output logic               reg_wr,
  output logic [WORD_W-1:0]  reg_wdata
);
  logic       wr_d, rd_d;
  logic [7:0] hi_byte;
  logic       narrow, access_ok;
  logic       wr_fire, rd_fire, idx_load, data_load;

  assign narrow    = is_narrow(width);
  assign access_ok = !cs_s && (width != BW_OFF);
  assign wr_fire   = wr_s && !wr_d && access_ok;
  assign rd_fire   = rd_s && !rd_d && access_ok && rs_s && narrow;
  assign idx_load  = wr_fire && !rs_s;
  assign data_load = wr_fire && rs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d        <= 1'b1;
      rd_d        <= 1'b1;
      index       <= '0;
      second_half <= 1'b0;
      hi_byte     <= '0;
      reg_wr      <= 1'b0;
      reg_wdata   <= '0;
    end else begin
      wr_d   <= wr_s;
      rd_d   <= rd_s;
      reg_wr <= 1'b0;
      if (idx_load) begin
        index       <= narrow ? narrow_byte(data_s) : wide_word(data_s)[7:0];
        second_half <= 1'b0;
      end else if (data_load) begin
        if (!narrow) begin
          reg_wr    <= 1'b1;
          reg_wdata <= wide_word(data_s);
        end else if (!second_half) begin
          hi_byte     <= narrow_byte(data_s);
          second_half <= 1'b1;
        end else begin
          reg_wr      <= 1'b1;
          reg_wdata   <= {hi_byte, narrow_byte(data_s)};
          second_half <= 1'b0;
        end
      end else if (rd_fire) begin
        second_half <= !second_half;
      end
    end
  end

  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R8
  AST_WR_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(width != BW_OFF)); // R5
  AST_WR_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(!cs_s)); // R6
  AST_INDEX_RESTARTS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> !second_half); // R7
  AST_INDEX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> !reg_wr); // R7
endmodule

// File: rtl/hbus_readout.sv
module hbus_readout
  import hbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_width_e        width,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              rs,
  input  logic [IDX_W-1:0]  index,
  input  logic              second_half,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic [BUS_W-1:0]  db_out,
  output logic              db_oe
);
  logic [7:0] sel_byte;

  always_comb begin
    sel_byte = second_half ? reg_rdata[7:0] : reg_rdata[15:8];
    if (is_narrow(width))
      db_out = place_narrow(rs ? sel_byte : index);
    else
      db_out = place_wide(rs ? reg_rdata : {8'h00, index});
  end

  assign db_oe = !cs_n && !rd_n && (width != BW_OFF);

  AST_OE_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !db_oe); // R6
endmodule

// File: rtl/hbus_port.sv
module hbus_port
  import hbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  mode_sel,
  input  logic        cs_n,
  input  logic        rs,
  input  logic        wr_n,
  input  logic        rd_n,
  input  logic [17:0] db_in,
  output logic [17:0] db_out,
  output logic        db_oe,
  output logic        reg_wr,
  output logic [7:0]  reg_addr,
  output logic [15:0] reg_wdata,
  input  logic [15:0] reg_rdata
);
  localparam int SW = BUS_W + 4;

  bus_width_e       width;
  logic [SW-1:0]    sync_q;
  logic             cs_s, rs_s, wr_s, rd_s;
  logic [BUS_W-1:0] data_s;
  logic             second_half;

  assign width = decode_mode(mode_sel);

  hbus_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({cs_n, rs, wr_n, rd_n, db_in}),
    .q (sync_q)
  );

  assign {cs_s, rs_s, wr_s, rd_s, data_s} = sync_q;

  hbus_capture u_cap (
    .clk (clk),
    .rst_n (rst_n),
    .width (width),
    .cs_s (cs_s),
    .rs_s (rs_s),
    .wr_s (wr_s),
    .rd_s (rd_s),
    .data_s (data_s),
    .index (reg_addr),
    .second_half (second_half),
    .reg_wr (reg_wr),
    .reg_wdata (reg_wdata)
  );

  hbus_readout u_rd (
    .clk (clk),
    .rst_n (rst_n),
    .width (width),
    .cs_n (cs_n),
    .rd_n (rd_n),
    .rs (rs),
    .index (reg_addr),
    .second_half (second_half),
    .reg_rdata (reg_rdata),
    .db_out (db_out),
    .db_oe (db_oe)
  );
endmodule

// File: tb/hbus_port_test.sv
module hbus_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_sel = 4'b0010;
  logic        cs_n = 1'b1, rs = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [17:0] db_in = '0;
  logic [17:0] db_out;
  logic        db_oe, reg_wr;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  logic [15:0] rf [256];
  int          cyc = 0, pulses = 0, pulse_cyc = 0, raise_cyc = 0;
  logic [7:0]  last_addr;
  logic [15:0] last_data;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  hbus_port uut (.*);

  assign reg_rdata = rf[reg_addr];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (reg_wr) begin
    pulses++;
    pulse_cyc = cyc;
    last_addr = reg_addr;
    last_data = reg_wdata;
    rf[reg_addr] = reg_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench-side lane helpers
  function automatic logic [17:0] wide_bus(input logic [15:0] v, input logic junk);
    return {v[15:8], junk, v[7:0], junk};
  endfunction
  function automatic logic [17:0] byte_bus(input logic [7:0] b, input logic l9);
    return {b, l9, 9'h000};
  endfunction

  task automatic do_write(input logic r, input logic [17:0] d, input logic sel_n);
    @(negedge clk);
    cs_n = sel_n; rs = r; db_in = d; wr_n = 1'b0;
    wait_n(4);
    wr_n = 1'b1; raise_cyc = cyc;
    wait_n(6);
    cs_n = 1'b1;
    wait_n(2);
  endtask

  task automatic do_read(input logic r, input logic sel_n, output logic [17:0] d, output logic oe);
    @(negedge clk);
    cs_n = sel_n; rs = r; rd_n = 1'b0;
    wait_n(3);
    d = db_out; oe = db_oe;
    rd_n = 1'b1;
    wait_n(6);
    cs_n = 1'b1;
    wait_n(2);
  endtask

  task automatic t_reset;
    check("R12 oe", db_oe, 0);
    check("R12 addr", reg_addr, 0);
    check("R12 pulses", pulses, 0);
    check("R12 wr", reg_wr, 0);
  endtask

  task automatic t_mode16;
    logic [17:0] d; logic oe; int p;
    mode_sel = 4'b0010;
    p = pulses;
    do_write(0, wide_bus(16'h0005, 1'b1), 0);
    check("R7 index", reg_addr, 8'h05);
    check("R7 no pulse", pulses, p);
    do_write(1, wide_bus(16'hA55A, 1'b1), 0);
    check("R1 pulse", pulses, p + 1);
    check("R1 data", last_data, 16'hA55A);
    check("R8 addr", last_addr, 8'h05);
    check("R8 latency", pulse_cyc - raise_cyc, 3);
    do_read(1, 0, d, oe);
    check("R9 oe", oe, 1);
    check("R9 data", d, wide_bus(16'hA55A, 1'b0));
    do_read(0, 0, d, oe);
    check("R11 wide index", d, wide_bus(16'h0005, 1'b0));
  endtask

  task automatic t_mode18;
    int p;
    mode_sel = 4'b1010;
    p = pulses;
    do_write(0, wide_bus(16'h0010, 1'b0), 0);
    do_write(1, wide_bus(16'h1234, 1'b1), 0);
    check("R2 pulse", pulses, p + 1);
    check("R2 data", last_data, 16'h1234);
    check("R2 addr", last_addr, 8'h10);
  endtask

  task automatic t_mode8;
    logic [17:0] d; logic oe; int p;
    mode_sel = 4'b0011;
    do_write(0, byte_bus(8'h20, 1'b0), 0);
    check("R7 narrow index", reg_addr, 8'h20);
    p = pulses;
    do_write(1, byte_bus(8'hBE, 1'b0), 0);
    check("R3 no pulse after upper", pulses, p);
    do_write(1, byte_bus(8'hEF, 1'b0), 0);
    check("R3 pulse", pulses, p + 1);
    check("R3 data", last_data, 16'hBEEF);
    do_read(1, 0, d, oe);
    check("R10 upper", d, byte_bus(8'hBE, 1'b0));
    do_read(1, 0, d, oe);
    check("R10 lower", d, byte_bus(8'hEF, 1'b0));
    do_read(1, 0, d, oe);
    check("R10 wraps", d, byte_bus(8'hBE, 1'b0));
    do_read(1, 0, d, oe);
    do_read(0, 0, d, oe);
    check("R11 narrow index", d, byte_bus(8'h20, 1'b0));
  endtask

  task automatic t_mode9;
    int p;
    mode_sel = 4'b1011;
    do_write(0, byte_bus(8'h21, 1'b1), 0);
    p = pulses;
    do_write(1, byte_bus(8'h12, 1'b1), 0);
    do_write(1, byte_bus(8'h34, 1'b1), 0);
    check("R4 pulse", pulses, p + 1);
    check("R4 data", last_data, 16'h1234);
    check("R4 addr", last_addr, 8'h21);
    do_write(1, byte_bus(8'h77, 1'b0), 0);
    do_write(0, byte_bus(8'h22, 1'b0), 0);
    do_write(1, byte_bus(8'h88, 1'b0), 0);
    check("R7 restart no pulse", pulses, p + 1);
    do_write(1, byte_bus(8'h99, 1'b0), 0);
    check("R7 restart data", last_data, 16'h8899);
    check("R7 restart addr", last_addr, 8'h22);
  endtask

  task automatic t_disabled;
    logic [17:0] d; logic oe; int p;
    logic [3:0] codes [4] = '{4'b0001, 4'b0110, 4'b1000, 4'b1101};
    p = pulses;
    for (int i = 0; i < 4; i++) begin
      mode_sel = codes[i];
      do_write(0, 18'h3FFFF, 0);
      do_write(1, 18'h3FFFF, 0);
      do_read(1, 0, d, oe);
      check("R5 oe", oe, 0);
    end
    check("R5 no pulse", pulses, p);
    check("R5 index kept", reg_addr, 8'h22);
  endtask

  task automatic t_deselected;
    logic [17:0] d; logic oe; int p;
    mode_sel = 4'b0010;
    p = pulses;
    do_write(0, wide_bus(16'h0044, 1'b0), 1);
    do_write(1, wide_bus(16'hFFFF, 1'b0), 1);
    check("R6 no pulse", pulses, p);
    check("R6 index kept", reg_addr, 8'h22);
    do_read(1, 1, d, oe);
    check("R6 oe", oe, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rf[i] = 16'h0000;
    wait_n(3);
    t_reset;
    rst_n = 1'b1;
    wait_n(3);
    t_mode16;
    t_mode18;
    t_mode8;
    t_mode9;
    t_disabled;
    t_deselected;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule